// File: doc/BRIEF.md
# Stop-Mode Power Sequencer

This block decides when a small microcontroller core may shut down its main oscillator, and how it comes back. Instruction decode raises a stop request for one cycle. If the main system clock is the selected CPU clock and no unmasked interrupt is waiting, the sequencer enters STOP. In STOP the main oscillator is turned off and the CPU clock is gated. A peripheral clock is kept only where that peripheral runs from the subsystem clock or from an external clock. The external bus and the output pins are parked in safe states.

A wake-up condition is any interrupt source whose request flag is set and whose mask flag is clear. Such a condition moves STOP into a stabilisation wait. The oscillator runs again during the wait, but the CPU clock stays off until a programmable number of oscillator cycles has elapsed. If a wake-up condition is already present when the stop request arrives, the block enters HALT instead of STOP. HALT keeps the oscillator running and returns to RUN with no wait. After reset the CPU is also released only after the stabilisation wait.

All pins are plain control levels. There is no data stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `stopseq_ctrl`

## Requirements
- R1: A stop request is acted on only while `main_clk_sel` is 1 and the state is RUN. Otherwise the state stays RUN and `cpu_clk_en` stays 1.
- R2: Wake-up is true when any source has `irq_req[i]`=1 and `irq_mask[i]`=0, and a masked request never wakes the block. A stop request that is accepted while wake-up is true enters HALT (`sleep_state`=1, `osc_en`=1, `cpu_clk_en`=0) and not STOP.
- R3: In HALT, wake-up returns the block to RUN on the next clock edge, with no stabilisation wait.
- R4: In STOP (`sleep_state`=2), `osc_en`=0 and `cpu_clk_en`=0, and `periph_clk_en` equals `periph_keep`. In RUN and HALT every bit of `periph_clk_en` is 1.
- R5: Wake-up in STOP enters the stabilisation wait (`sleep_state`=3). The wait lasts exactly T cycles, where T = 2^(E-DLY_SCALE) and E is selected by `stab_sel`: 0 gives 12, 1 gives 14, 2 gives 15, 3 gives 16, and 4 to 7 give 17. The code is latched on the wake-up edge.
- R6: The stabilisation count restarts from zero on every wake-up from STOP, so repeated stops with the same code give the same wait.
- R7: In STOP and in the wait, `pad_ad_oe`=0, `pad_wait_oe`=0, `pad_astb`=0, `pad_rd_n`=1 and `pad_wr_n`=1. `pad_addr_hi` holds the value `core_addr_hi` had at entry. In RUN and HALT all bus pads follow the core.
- R8: In STOP and in the wait, `pad_buz` is 0. `pad_clkout` follows `clkout_in` when `clkout_from_sub`=1 and is 0 otherwise.
- R9: While `rst_n` is 0, the state is the stabilisation wait with `osc_en`=1 and `cpu_clk_en`=0. After release the wait lasts the longest delay (E=17) before RUN.
- R10: `sleep_state` encodes RUN=0, HALT=1, STOP=2, WAIT=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop instruction decoded |
| main_clk_sel | input | 1 | 1 when the main system clock is the CPU clock |
| irq_req | input | NUM_SRC | Interrupt request flags |
| irq_mask | input | NUM_SRC | Interrupt mask flags (1 = masked) |
| stab_sel | input | 3 | Stabilisation time select code |
| periph_keep | input | NUM_PERIPH | Peripherals clocked from the subsystem or an external clock |
| clkout_from_sub | input | 1 | Clock output is sourced from the subsystem clock |
| clkout_in | input | 1 | Clock output level from the clock divider |
| buz_in | input | 1 | Buzzer level from the peripheral |
| core_ad_out | input | AD_W | Core low address/data out |
| core_ad_oe | input | 1 | Core low address/data output enable |
| core_addr_hi | input | AHI_W | Core upper address |
| core_astb | input | 1 | Core address strobe |
| core_rd_n | input | 1 | Core read strobe, active low |
| core_wr_n | input | 1 | Core write strobe, active low |
| core_wait_oe | input | 1 | Core wait line output enable |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock gate enables |
| sleep_state | output | 2 | Current power state |
| pad_ad_out | output | AD_W | Low address/data pad value |
| pad_ad_oe | output | 1 | Low address/data pad enable |
| pad_addr_hi | output | AHI_W | Upper address pads |
| pad_astb | output | 1 | Address strobe pad |
| pad_rd_n | output | 1 | Read strobe pad |
| pad_wr_n | output | 1 | Write strobe pad |
| pad_wait_oe | output | 1 | Wait pad enable |
| pad_buz | output | 1 | Buzzer pad |
| pad_clkout | output | 1 | Clock output pad |

## Verification
On every cycle, the assertions check that the state moves only along legal transitions. They cover refused stops without the main clock, the diversion into HALT when a wake-up is pending, and the exits from HALT and STOP. They also check that the stabilisation counter never reaches its target while waiting, and that the upper address pads latch the entry value and then stay still. The bench scenarios are needed for the exact length of each wait across all eight select codes, the reset wait, and the pin and clock-gate levels themselves. They also cover the per-source check that masked requests do not wake.

// File: rtl/stopseq_pkg.sv
package stopseq_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HALT = 2'd1,
    PS_STOP = 2'd2,
    PS_WAIT = 2'd3
  } pwr_state_e;

  localparam int unsigned STAB_EXP_MAX = 17;

  // Map the select code to a power-of-two exponent of oscillator cycles.
  function automatic int unsigned stab_exp(input logic [2:0] code);
    case (code)
      3'd0:    stab_exp = 12;
      3'd1:    stab_exp = 14;
      3'd2:    stab_exp = 15;
      3'd3:    stab_exp = 16;
      default: stab_exp = STAB_EXP_MAX;
    endcase
  endfunction

endpackage

// File: rtl/stopseq_wake.sv
module stopseq_wake #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_mask,
  output logic               wake
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = irq_req[i] & ~irq_mask[i];
  end

  assign wake = |hit;
endmodule

// File: rtl/stopseq_stab_timer.sv
module stopseq_stab_timer
  import stopseq_pkg::*;
#(
  parameter int DLY_SCALE = 0,
  localparam int CNT_W = STAB_EXP_MAX + 1 - DLY_SCALE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] LONGEST = ONE << (STAB_EXP_MAX - DLY_SCALE);

  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= LONGEST;
      cnt_q    <= '0;
    end else if (start) begin
      target_q <= ONE << (stab_exp(sel) - DLY_SCALE);
      cnt_q    <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign done = run && (cnt_q == target_q - ONE);

  assert_cnt_below_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < target_q));
endmodule

// File: rtl/stopseq_pins.sv
module stopseq_pins #(
  parameter int AD_W  = 8,
  parameter int AHI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             clkout_from_sub,
  input  logic             clkout_in,
  input  logic             buz_in,
  input  logic [AD_W-1:0]  core_ad_out,
  input  logic             core_ad_oe,
  input  logic [AHI_W-1:0] core_addr_hi,
  input  logic             core_astb,
  input  logic             core_rd_n,
  input  logic             core_wr_n,
  input  logic             core_wait_oe,
  output logic [AD_W-1:0]  pad_ad_out,
  output logic             pad_ad_oe,
  output logic [AHI_W-1:0] pad_addr_hi,
  output logic             pad_astb,
  output logic             pad_rd_n,
  output logic             pad_wr_n,
  output logic             pad_wait_oe,
  output logic             pad_buz,
  output logic             pad_clkout
);
  logic [AHI_W-1:0] ahi_hold_q;

  // Track the upper address while running; the last value sticks once frozen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ahi_hold_q <= '0;
    else if (!freeze) ahi_hold_q <= core_addr_hi;
  end

  assign pad_ad_out  = core_ad_out;
  assign pad_ad_oe   = freeze ? 1'b0 : core_ad_oe;
  assign pad_addr_hi = freeze ? ahi_hold_q : core_addr_hi;
  assign pad_astb    = freeze ? 1'b0 : core_astb;
  assign pad_rd_n    = freeze ? 1'b1 : core_rd_n;
  assign pad_wr_n    = freeze ? 1'b1 : core_wr_n;
  assign pad_wait_oe = freeze ? 1'b0 : core_wait_oe;
  assign pad_buz     = freeze ? 1'b0 : buz_in;
  assign pad_clkout  = (freeze && !clkout_from_sub) ? 1'b0 : clkout_in;

  assert_ahi_latched_at_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze) |-> (pad_addr_hi == $past(core_addr_hi)));

  assert_ahi_stable_while_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (!freeze || $stable(pad_addr_hi)));
endmodule

// File: rtl/stopseq_ctrl.sv
module stopseq_ctrl
  import stopseq_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int NUM_PERIPH = 6,
  parameter int AD_W       = 8,
  parameter int AHI_W      = 8,
  parameter int DLY_SCALE  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_req,
  input  logic                  main_clk_sel,
  input  logic [NUM_SRC-1:0]    irq_req,
  input  logic [NUM_SRC-1:0]    irq_mask,
  input  logic [2:0]            stab_sel,
  input  logic [NUM_PERIPH-1:0] periph_keep,
  input  logic                  clkout_from_sub,
  input  logic                  clkout_in,
  input  logic                  buz_in,
  input  logic [AD_W-1:0]       core_ad_out,
  input  logic                  core_ad_oe,
  input  logic [AHI_W-1:0]      core_addr_hi,
  input  logic                  core_astb,
  input  logic                  core_rd_n,
  input  logic                  core_wr_n,
  input  logic                  core_wait_oe,
  output logic                  osc_en,
  output logic                  cpu_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic [1:0]            sleep_state,
  output logic [AD_W-1:0]       pad_ad_out,
  output logic                  pad_ad_oe,
  output logic [AHI_W-1:0]      pad_addr_hi,
  output logic                  pad_astb,
  output logic                  pad_rd_n,
  output logic                  pad_wr_n,
  output logic                  pad_wait_oe,
  output logic                  pad_buz,
  output logic                  pad_clkout
);
  pwr_state_e st_q, st_d;
  logic wake, stab_done, frozen;

  stopseq_wake #(.NUM_SRC(NUM_SRC)) u_wake (
    .irq_req (irq_req),
    .irq_mask(irq_mask),
    .wake    (wake)
  );

  stopseq_stab_timer #(.DLY_SCALE(DLY_SCALE)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(st_q == PS_STOP && wake),
    .run  (st_q == PS_WAIT),
    .sel  (stab_sel),
    .done (stab_done)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_RUN:  if (stop_req && main_clk_sel) st_d = wake ? PS_HALT : PS_STOP;
      PS_HALT: if (wake) st_d = PS_RUN;
      PS_STOP: if (wake) st_d = PS_WAIT;
      PS_WAIT: if (stab_done) st_d = PS_RUN;
      default: st_d = PS_RUN;
    endcase
  end

  // Reset lands in the wait so the CPU is released only after stabilisation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_WAIT;
    else        st_q <= st_d;
  end

  assign frozen        = (st_q == PS_STOP) || (st_q == PS_WAIT);
  assign osc_en        = (st_q != PS_STOP);
  assign cpu_clk_en    = (st_q == PS_RUN);
  assign periph_clk_en = frozen ? periph_keep : '1;
  assign sleep_state   = st_q;

  stopseq_pins #(.AD_W(AD_W), .AHI_W(AHI_W)) u_pins (
    .clk            (clk),
    .rst_n          (rst_n),
    .freeze         (frozen),
    .clkout_from_sub(clkout_from_sub),
    .clkout_in      (clkout_in),
    .buz_in         (buz_in),
    .core_ad_out    (core_ad_out),
    .core_ad_oe     (core_ad_oe),
    .core_addr_hi   (core_addr_hi),
    .core_astb      (core_astb),
    .core_rd_n      (core_rd_n),
    .core_wr_n      (core_wr_n),
    .core_wait_oe   (core_wait_oe),
    .pad_ad_out     (pad_ad_out),
    .pad_ad_oe      (pad_ad_oe),
    .pad_addr_hi    (pad_addr_hi),
    .pad_astb       (pad_astb),
    .pad_rd_n       (pad_rd_n),
    .pad_wr_n       (pad_wr_n),
    .pad_wait_oe    (pad_wait_oe),
    .pad_buz        (pad_buz),
    .pad_clkout     (pad_clkout)
  );

  assert_stop_needs_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && !main_clk_sel) |=> (st_q == PS_RUN));

  assert_pending_diverts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && wake) |=> (st_q != PS_STOP));

  assert_halt_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HALT) |=> (st_q == PS_HALT || st_q == PS_RUN));

  assert_stop_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_STOP) |=> (st_q == PS_STOP || st_q == PS_WAIT));
endmodule

// File: tb/stopseq_ctrl_tb.sv
module stopseq_ctrl_tb;
  localparam int NS = 4;
  localparam int NP = 4;
  localparam int SC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, main_clk_sel = 1'b1;
  logic [NS-1:0] irq_req = '0, irq_mask = '0;
  logic [2:0] stab_sel = 3'd0;
  logic [NP-1:0] periph_keep = 4'b0101;
  logic clkout_from_sub = 1'b0, clkout_in = 1'b1, buz_in = 1'b1;
  logic [7:0] core_ad_out = 8'h3C, core_addr_hi = 8'hA5;
  logic core_ad_oe = 1'b1, core_astb = 1'b1, core_rd_n = 1'b0, core_wr_n = 1'b0, core_wait_oe = 1'b1;
  logic osc_en, cpu_clk_en;
  logic [NP-1:0] periph_clk_en;
  logic [1:0] sleep_state;
  logic [7:0] pad_ad_out, pad_addr_hi;
  logic pad_ad_oe, pad_astb, pad_rd_n, pad_wr_n, pad_wait_oe, pad_buz, pad_clkout;

  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  stopseq_ctrl #(.NUM_SRC(NS), .NUM_PERIPH(NP), .AD_W(8), .AHI_W(8), .DLY_SCALE(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .main_clk_sel(main_clk_sel),
    .irq_req(irq_req), .irq_mask(irq_mask), .stab_sel(stab_sel), .periph_keep(periph_keep),
    .clkout_from_sub(clkout_from_sub), .clkout_in(clkout_in), .buz_in(buz_in),
    .core_ad_out(core_ad_out), .core_ad_oe(core_ad_oe), .core_addr_hi(core_addr_hi),
    .core_astb(core_astb), .core_rd_n(core_rd_n), .core_wr_n(core_wr_n),
    .core_wait_oe(core_wait_oe), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .sleep_state(sleep_state), .pad_ad_out(pad_ad_out),
    .pad_ad_oe(pad_ad_oe), .pad_addr_hi(pad_addr_hi), .pad_astb(pad_astb),
    .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n), .pad_wait_oe(pad_wait_oe),
    .pad_buz(pad_buz), .pad_clkout(pad_clkout)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wait(input int code);
    int e;
    e = (code == 0) ? 12 : (code == 1) ? 14 : (code == 2) ? 15 : (code == 3) ? 16 : 17;
    return 1 << (e - SC);
  endfunction

  // Counts samples spent in the wait state, starting at the current sample.
  task automatic count_wait(output int n);
    n = 0;
    while (sleep_state == 2'd3 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_stop(input int code, input int src, input string tag);
    int n;
    logic [7:0] held;
    held = core_addr_hi;
    @(negedge clk);
    stab_sel = 3'(code);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R4 state stop", int'(sleep_state), 2);
    chk("R4 osc_en", int'(osc_en), 0);
    chk("R4 cpu_clk_en", int'(cpu_clk_en), 0);
    chk("R4 periph_clk_en", int'(periph_clk_en), int'(periph_keep));
    core_addr_hi = ~held;
    clkout_from_sub = 1'b0;
    @(negedge clk);
    chk("R7 addr_hi held", int'(pad_addr_hi), int'(held));
    chk("R7 ad_oe", int'(pad_ad_oe), 0);
    chk("R7 astb", int'(pad_astb), 0);
    chk("R7 rd_n", int'(pad_rd_n), 1);
    chk("R7 wr_n", int'(pad_wr_n), 1);
    chk("R7 wait_oe", int'(pad_wait_oe), 0);
    chk("R8 buz low", int'(pad_buz), 0);
    chk("R8 clkout low", int'(pad_clkout), 0);
    clkout_from_sub = 1'b1;
    #1 chk("R8 clkout from sub", int'(pad_clkout), int'(clkout_in));
    irq_req[src] = 1'b1;
    irq_mask[src] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 masked no wake", int'(sleep_state), 2);
    irq_mask[src] = 1'b0;
    @(negedge clk);
    irq_req = '0;
    stab_sel = 3'(7 - code);
    chk("R7 addr_hi held in wait", int'(pad_addr_hi), int'(held));
    count_wait(n);
    chk(tag, n, exp_wait(code));
    chk("R10 run after wait", int'(sleep_state), 0);
    chk("R7 addr_hi follows core", int'(pad_addr_hi), int'(core_addr_hi));
    clkout_from_sub = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R9 reset state wait", int'(sleep_state), 3);
    chk("R9 reset osc_en", int'(osc_en), 1);
    chk("R9 reset cpu gated", int'(cpu_clk_en), 0);
    rst_n = 1'b1;
    count_wait(n);
    chk("R9 reset wait length", n, exp_wait(7));
    chk("R10 run code", int'(sleep_state), 0);
    chk("R4 periph all on in run", int'(periph_clk_en), 15);

    // R1: refused stop without main clock
    @(negedge clk);
    main_clk_sel = 1'b0;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R1 stays run", int'(sleep_state), 0);
    chk("R1 cpu clock on", int'(cpu_clk_en), 1);
    @(negedge clk);
    chk("R1 still run", int'(sleep_state), 0);
    main_clk_sel = 1'b1;

    // R2/R3: pending wake diverts to halt, exits with no wait
    for (int s = 0; s < NS; s++) begin
      irq_req[s] = 1'b1;
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      chk("R2 halt state", int'(sleep_state), 1);
      chk("R2 halt osc on", int'(osc_en), 1);
      chk("R2 halt cpu gated", int'(cpu_clk_en), 0);
      chk("R4 halt periph all on", int'(periph_clk_en), 15);
      chk("R7 halt astb follows", int'(pad_astb), 1);
      @(negedge clk);
      chk("R3 halt to run", int'(sleep_state), 0);
      irq_req = '0;
      @(negedge clk);
    end

    // R5: sweep all select codes
    for (int c = 0; c < 8; c++) begin
      core_addr_hi = 8'(8'h11 * (c + 1));
      do_stop(c, c % NS, "R5 wait length");
    end

    // R6: repeated stops give the same full wait
    for (int k = 0; k < 3; k++) do_stop(1, k, "R6 wait restarts");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule